// File: doc/BRIEF.md
# Masked Tower-Field Byte Inverter

This block returns the multiplicative inverse of a byte of GF(2^8) while the byte stays hidden under an additive mask from input to output. The caller supplies the byte already XORed with an 8-bit input mask, the input mask itself, an 8-bit output mask and a 4-bit temporary mask. The registered result is the true inverse XORed with the output mask. The caller's unmasked data never appears on any internal net.

All arithmetic uses a composite field. The byte is a pair of GF(2^4) elements over a normal basis, and each of those is a pair of GF(2^2) elements, also over a normal basis. A masked GF(2^4) inverter sits inside. It takes the intermediate value masked by the temporary mask and hands back its inverse re-masked by the upper half of the input mask. Every correction sum starts from a mask and folds in one term at a time, so no partial sum is ever a bare product of data terms.

A build parameter picks one of two variants. The dual-mask variant uses independent input and output masks. The shared-mask variant returns the result under the input mask and uses the temporary mask to protect its output sums.

Top module: `masked_tower_inv`

## Requirements
- R1: While reset is asserted, the registered output is 8'h00.
- R2: The result appears on the output one rising clock edge after the inputs are applied. Before that edge, the output keeps its previous value.
- R3: Byte encoding: the high nibble is the coefficient of Y^16 and the low nibble is the coefficient of Y, where Y^2+Y+N=0 and N=4'b1000. In a nibble, bits [3:2] are the coefficient of Z^4 and bits [1:0] are the coefficient of Z, where Z^2+Z+n=0 and n=2'b10. In a pair, bit 1 is the coefficient of w^2 and bit 0 is the coefficient of w, where w^2+w+1=0. With SINGLE_MASK=0, the output equals the inverse of (data_m XOR mask_in) XOR mask_out, for all 256 data values. Under a field isomorphism, this matches the inverse in the standard x^8+x^4+x^3+x+1 field.
- R4: With SINGLE_MASK=1, the output equals the inverse of (data_m XOR mask_in) XOR mask_in. The value on mask_out has no effect on the output.
- R5: Zero data yields zero data: if data_m equals mask_in, the output equals the selected output mask.
- R6: The field unit 8'hFF maps to itself under any masks.
- R7: For fixed unmasked data and a fixed output mask, the output does not depend on mask_in or mask_tmp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_m | input | 8 | Data byte XOR input mask, tower basis |
| mask_in | input | 8 | Input mask |
| mask_out | input | 8 | Output mask (dual-mask variant only) |
| mask_tmp | input | 4 | Temporary mask that opens the first correction chain |
| result_m | output | 8 | Inverse XOR output mask, registered |

## Verification
The bench instantiates the block twice on the same stimulus: once with SINGLE_MASK=0 and once with SINGLE_MASK=1. One sweep of all 256 data values therefore tests both output-chain variants. The bench searches for a root of the standard reduction polynomial in the tower field to build the basis mapping. With that mapping, each unmasked result can be compared with a standard-field inverse table. Separate scenarios hold the data fixed while the masks vary, toggle the output mask in the shared-mask variant, and cover the zero and unit bytes.

// File: rtl/mti_pkg.sv
package mti_pkg;

    localparam int PAIR_W   = 2;
    localparam int NIB_W    = 2 * PAIR_W;
    localparam int BYTE_W   = 2 * NIB_W;

    // Norm of the GF(2^4)/GF(2^2) normal basis (w^2) and of GF(2^8)/GF(2^4) (w^2*Z^4)
    localparam logic [PAIR_W-1:0] SUB_NORM = 2'b10;
    localparam logic [NIB_W-1:0]  TOP_NORM = 4'b1000;

    typedef logic [PAIR_W-1:0] pair_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // GF(2^2) product, normal basis [w^2, w]
    function automatic pair_t p_mul(input pair_t a, input pair_t b);
        logic s;
        s = (a[1] ^ a[0]) & (b[1] ^ b[0]);
        return {(a[1] & b[1]) ^ s, (a[0] & b[0]) ^ s};
    endfunction

    // Squaring in GF(2^2) is a swap of the two coordinates
    function automatic pair_t p_sq(input pair_t a);
        return {a[0], a[1]};
    endfunction

    // Fused square and norm scale in GF(2^2)
    function automatic pair_t p_sqscl(input pair_t a);
        return p_mul(p_sq(a), SUB_NORM);
    endfunction

    // GF(2^4) product, normal basis [Z^4, Z]
    function automatic nib_t n_mul(input nib_t a, input nib_t b);
        pair_t e;
        e = p_mul(p_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]), SUB_NORM);
        return {p_mul(a[3:2], b[3:2]) ^ e, p_mul(a[1:0], b[1:0]) ^ e};
    endfunction

    // Fused square and norm scale in GF(2^4)
    function automatic nib_t n_sqscl(input nib_t a);
        pair_t t;
        nib_t  sq;
        t  = p_sqscl(a[3:2] ^ a[1:0]);
        sq = {p_sq(a[3:2]) ^ t, p_sq(a[1:0]) ^ t};
        return n_mul(sq, TOP_NORM);
    endfunction

endpackage

// File: rtl/mti_sub_inv.sv
// Masked GF(2^4) inverter: input masked by q, output masked by m_hi.
module mti_sub_inv
    import mti_pkg::*;
(
    input  logic [NIB_W-1:0]  b_m,
    input  logic [NIB_W-1:0]  q,
    input  logic [PAIR_W-1:0] r,
    input  logic [NIB_W-1:0]  m_hi,
    output logic [NIB_W-1:0]  binv_m
);

    pair_t b1, b0, q1, q0, qq;
    pair_t c_s0, c_s1, c_s2, c_s3, c_s4, c_s5, c_s6;
    pair_t ci_sw, ci_s1, ci_q1, qsum, ci_q0;
    pair_t h_s0, h_s1, h_s2, h_s3, h_s4;
    pair_t l_s0, l_s1, l_s2, l_s3, l_s4;

    always_comb begin
        b1 = b_m[3:2];
        b0 = b_m[1:0];
        q1 = q[3:2];
        q0 = q[1:0];
        qq = p_mul(q1, q0);

        // masked norm value, opened by r, one term at a time
        c_s0 = r;
        c_s1 = c_s0 ^ p_sqscl(b1 ^ b0);
        c_s2 = c_s1 ^ p_sqscl(q1 ^ q0);
        c_s3 = c_s2 ^ p_mul(b1, b0);
        c_s4 = c_s3 ^ p_mul(b1, q0);
        c_s5 = c_s4 ^ p_mul(b0, q1);
        c_s6 = c_s5 ^ qq;

        // inverse by swap, then switch mask r^2 -> q1 (q1 added first)
        ci_sw = p_sq(c_s6);
        ci_s1 = ci_sw ^ q1;
        ci_q1 = ci_s1 ^ p_sq(r);

        // high pair, masked by m_hi[3:2]
        h_s0 = m_hi[3:2];
        h_s1 = h_s0 ^ p_mul(b0, ci_q1);
        h_s2 = h_s1 ^ p_mul(b0, q1);
        h_s3 = h_s2 ^ p_mul(q0, ci_q1);
        h_s4 = h_s3 ^ qq;

        // switch mask q1 -> q0; pair sum formed before it is applied
        qsum  = q0 ^ q1;
        ci_q0 = ci_q1 ^ qsum;

        // low pair, masked by m_hi[1:0]
        l_s0 = m_hi[1:0];
        l_s1 = l_s0 ^ p_mul(b1, ci_q0);
        l_s2 = l_s1 ^ p_mul(b1, q0);
        l_s3 = l_s2 ^ p_mul(q1, ci_q0);
        l_s4 = l_s3 ^ qq;

        binv_m = {h_s4, l_s4};
    end

endmodule

// File: rtl/mti_half_chain.sv
// One output half: start ^ x*y ^ x*ky ^ kx*y ^ kxky ^ tail, in that order.
module mti_half_chain
    import mti_pkg::*;
(
    input  logic [NIB_W-1:0] start,
    input  logic [NIB_W-1:0] x_m,
    input  logic [NIB_W-1:0] x_k,
    input  logic [NIB_W-1:0] y_m,
    input  logic [NIB_W-1:0] y_k,
    input  logic [NIB_W-1:0] kxky,
    input  logic [NIB_W-1:0] tail,
    output logic [NIB_W-1:0] res
);

    nib_t s1, s2, s3, s4;

    always_comb begin
        s1  = start ^ n_mul(x_m, y_m);
        s2  = s1 ^ n_mul(x_m, y_k);
        s3  = s2 ^ n_mul(x_k, y_m);
        s4  = s3 ^ kxky;
        res = s4 ^ tail;
    end

endmodule

// File: rtl/masked_tower_inv.sv
module masked_tower_inv
    import mti_pkg::*;
#(
    parameter bit SINGLE_MASK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_m,
    input  logic [BYTE_W-1:0] mask_in,
    input  logic [BYTE_W-1:0] mask_out,
    input  logic [NIB_W-1:0]  mask_tmp,
    output logic [BYTE_W-1:0] result_m
);

    typedef struct packed {
        byte_t res;
    } state_t;

    state_t st_d, st_q;

    nib_t a1, a0, k1, k0, kk, k01;
    nib_t b_s0, b_s1, b_s2, b_s3, b_s4, b_s5, b_s6;
    nib_t binv_k1, b2_k0;
    nib_t hi_start, hi_tail, lo_start, lo_tail, hi_res, lo_res;
    byte_t res_mask;

    assign a1 = data_m[7:4];
    assign a0 = data_m[3:0];
    assign k1 = mask_in[7:4];
    assign k0 = mask_in[3:0];
    assign kk = n_mul(k0, k1);   // shared by both output halves

    // masked norm value, opened by the temporary mask
    assign b_s0 = mask_tmp;
    assign b_s1 = b_s0 ^ n_sqscl(a1 ^ a0);
    assign b_s2 = b_s1 ^ n_sqscl(k1 ^ k0);
    assign b_s3 = b_s2 ^ n_mul(a1, a0);
    assign b_s4 = b_s3 ^ n_mul(a1, k0);
    assign b_s5 = b_s4 ^ n_mul(a0, k1);
    assign b_s6 = b_s5 ^ kk;

    mti_sub_inv u_sub (
        .b_m    (b_s6),
        .q      (mask_tmp),
        .r      (k0[1:0]),
        .m_hi   (k1),
        .binv_m (binv_k1)
    );

    // move subfield inverse from mask k1 to mask k0
    assign k01   = k0 ^ k1;
    assign b2_k0 = binv_k1 ^ k01;

    generate
        if (SINGLE_MASK) begin : g_shared
            assign hi_start = mask_tmp;
            assign lo_start = mask_tmp;
            assign hi_tail  = k1 ^ mask_tmp;
            assign lo_tail  = k0 ^ mask_tmp;
            assign res_mask = mask_in;
        end else begin : g_dual
            assign hi_start = mask_out[7:4];
            assign lo_start = mask_out[3:0];
            assign hi_tail  = '0;
            assign lo_tail  = '0;
            assign res_mask = mask_out;
        end
    endgenerate

    mti_half_chain u_hi (
        .start (hi_start),
        .x_m   (a0),
        .x_k   (k0),
        .y_m   (binv_k1),
        .y_k   (k1),
        .kxky  (kk),
        .tail  (hi_tail),
        .res   (hi_res)
    );

    mti_half_chain u_lo (
        .start (lo_start),
        .x_m   (a1),
        .x_k   (k1),
        .y_m   (b2_k0),
        .y_k   (k0),
        .kxky  (kk),
        .tail  (lo_tail),
        .res   (lo_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = {hi_res, lo_res};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_m = st_q.res;

    // ---------------- assertions ----------------
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= 2'd0;
        else if (age_q != 2) age_q <= age_q + 2'd1;
    end

    p_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && $past(data_m) == $past(mask_in)) |-> (result_m == $past(res_mask)));

    p_unit_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && ($past(data_m) ^ $past(mask_in)) == 8'hFF)
            |-> ((result_m ^ $past(res_mask)) == 8'hFF));

    // subfield inverse of zero comes back as the bare upper input-mask half
    p_sub_remask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_s6 == mask_tmp) |-> (binv_k1 == k1));

    p_mask_indep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2
         && ($past(data_m) ^ $past(mask_in)) == ($past(data_m, 2) ^ $past(mask_in, 2))
         && $past(res_mask) == $past(res_mask, 2))
            |-> $stable(result_m));

endmodule

// File: tb/tb_masked_tower_inv.sv
module tb_masked_tower_inv;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ONE_T = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_m = '0, mask_in = '0, mask_out = '0;
    logic [3:0] mask_tmp = '0;
    logic [7:0] res_d, res_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] to_tw   [256];
    logic [7:0] from_tw [256];
    logic [7:0] std_inv [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_tower_inv #(.SINGLE_MASK(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .data_m(data_m), .mask_in(mask_in),
        .mask_out(mask_out), .mask_tmp(mask_tmp), .result_m(res_d));

    masked_tower_inv #(.SINGLE_MASK(1'b1)) dut_sm (
        .clk(clk), .rst_n(rst_n), .data_m(data_m), .mask_in(mask_in),
        .mask_out(mask_out), .mask_tmp(mask_tmp), .result_m(res_s));

    // reference arithmetic from the basis definitions in R3
    function automatic logic [1:0] f4(input logic [1:0] a, input logic [1:0] b);
        logic s;
        s = (a[0] ^ a[1]) & (b[0] ^ b[1]);
        return {(a[1] & b[1]) ^ s, (a[0] & b[0]) ^ s};
    endfunction

    function automatic logic [3:0] f16(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] e;
        e = f4(f4(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]), 2'b10);
        return {f4(a[3:2], b[3:2]) ^ e, f4(a[1:0], b[1:0]) ^ e};
    endfunction

    function automatic logic [7:0] f256(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] e;
        e = f16(f16(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]), 4'b1000);
        return {f16(a[7:4], b[7:4]) ^ e, f16(a[3:0], b[3:0]) ^ e};
    endfunction

    function automatic logic [7:0] std_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p, x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] d, input logic [7:0] mi,
                         input logic [7:0] mo, input logic [3:0] mt);
        @(negedge clk);
        data_m = d; mask_in = mi; mask_out = mo; mask_tmp = mt;
        @(negedge clk);
    endtask

    task automatic build_ref();
        logic [7:0] pw [9];
        logic [7:0] root;
        bit found;
        found = 1'b0;
        root = 8'h00;
        for (int c = 1; c < 256; c++) begin
            if (!found) begin
                pw[0] = ONE_T;
                for (int k = 1; k < 9; k++) pw[k] = f256(pw[k-1], 8'(c));
                if ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00) begin
                    found = 1'b1;
                    root = 8'(c);
                end
            end
        end
        pw[0] = ONE_T;
        for (int k = 1; k < 8; k++) pw[k] = f256(pw[k-1], root);
        for (int d = 0; d < 256; d++) begin
            logic [7:0] t;
            t = 8'h00;
            for (int k = 0; k < 8; k++) if (d[k]) t = t ^ pw[k];
            to_tw[d] = t;
            from_tw[t] = 8'(d);
        end
        for (int a = 0; a < 256; a++) begin
            std_inv[a] = 8'h00;
            for (int b = 1; b < 256; b++)
                if (std_mul(8'(a), 8'(b)) == 8'h01) std_inv[a] = 8'(b);
        end
    endtask

    task automatic t_reset();
        data_m = 8'h5A; mask_in = 8'hC3; mask_out = 8'h3C; mask_tmp = 4'h9;
        repeat (3) @(negedge clk);
        chk("R1 reset dual", res_d, 8'h00);
        chk("R1 reset shared", res_s, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        apply(8'h6E, 8'h6E, 8'hA1, 4'h2);        // zero data
        chk("R2 settle", res_d, 8'hA1);
        data_m = ONE_T ^ 8'h17; mask_in = 8'h17; mask_out = 8'h4D; mask_tmp = 4'hE;
        #1;
        chk("R2 hold before edge", res_d, 8'hA1);
        @(negedge clk);
        chk("R2 after one edge", res_d, ONE_T ^ 8'h4D);
    endtask

    task automatic t_sweep();
        for (int d = 0; d < 256; d++) begin
            logic [7:0] mi, mo;
            logic [3:0] mt;
            mi = 8'($urandom);
            mo = 8'($urandom);
            mt = 4'($urandom);
            apply(to_tw[d] ^ mi, mi, mo, mt);
            chk("R3 dual-mask inverse", from_tw[res_d ^ mo], std_inv[d]);
            chk("R4 shared-mask inverse", from_tw[res_s ^ mi], std_inv[d]);
        end
    endtask

    task automatic t_out_mask_ignored();
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a, mi;
            logic [3:0] mt;
            logic [7:0] first;
            a  = to_tw[8'($urandom)];
            mi = 8'($urandom);
            mt = 4'($urandom);
            apply(a ^ mi, mi, 8'h00, mt);
            first = res_s;
            apply(a ^ mi, mi, 8'($urandom), mt);
            chk("R4 mask_out ignored", res_s, first);
        end
    endtask

    task automatic t_zero();
        for (int i = 0; i < 6; i++) begin
            logic [7:0] mi, mo;
            mi = 8'($urandom);
            mo = 8'($urandom);
            apply(mi, mi, mo, 4'($urandom));
            chk("R5 zero dual", res_d, mo);
            chk("R5 zero shared", res_s, mi);
        end
    endtask

    task automatic t_one();
        for (int i = 0; i < 6; i++) begin
            logic [7:0] mi, mo;
            mi = 8'($urandom);
            mo = 8'($urandom);
            apply(ONE_T ^ mi, mi, mo, 4'($urandom));
            chk("R6 unit dual", res_d ^ mo, ONE_T);
            chk("R6 unit shared", res_s ^ mi, ONE_T);
        end
    endtask

    task automatic t_mask_indep();
        logic [7:0] a, mo, ref_d;
        a  = to_tw[8'h53];
        mo = 8'h9B;
        apply(a ^ 8'h00, 8'h00, mo, 4'h0);
        ref_d = res_d;
        chk("R7 base equals inverse", from_tw[ref_d ^ mo], std_inv[8'h53]);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] mi;
            mi = 8'($urandom);
            apply(a ^ mi, mi, mo, 4'($urandom));
            chk("R7 independent of mask_in and mask_tmp", res_d, ref_d);
        end
    endtask

    initial begin
        build_ref();
        t_reset();
        t_latency();
        t_sweep();
        t_out_mask_ignored();
        t_zero();
        t_one();
        t_mask_indep();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule